// File: doc/BRIEF.md
# Two-Stage Clock Generator Reset Sequencer

This block releases reset in two chained steps across two clock domains. Running on a free external clock, the first stage holds the clock generator (PLL) in reset after power-up. It lets the PLL go once a fixed number of external clock edges have passed. The second stage runs on the PLL output clock and drives the system reset for the logic behind the PLL. That reset may only begin its countdown while the PLL reports lock and the external reset button is released. From that point it stays asserted for a fixed number of PLL clock edges.

Each delay is a shift register that fills with ones. The second stage is cleared asynchronously whenever lock is lost or the button is pressed. The system reset therefore asserts at once, with no clock edge needed. The lock flag and the button are brought into the PLL domain through a two-flop synchronizer, so the system reset is released only on a PLL clock edge.

Top module: `pll_rst_seq`

## Requirements
- R1: `pll_rst_o` is 1 from power-up through the first `PLL_HOLD` rising edges of `ext_clk_i` (default 16). It becomes 0 at the `PLL_HOLD`-th edge.
- R2: Once `pll_rst_o` is 0 it stays 0, whatever the other inputs do.
- R3: `sys_rst_o` is 1 at every `pll_clk_i` edge where `pll_locked_i` is 0 or `ext_rst_ni` is 0. The button input is active low: 0 means pressed.
- R4: When `pll_locked_i` falls or `ext_rst_ni` goes to 0, `sys_rst_o` becomes 1 without waiting for a `pll_clk_i` edge.
- R5: Suppose `pll_locked_i`=1 and `ext_rst_ni`=1 hold without a break. Then `sys_rst_o` becomes 0 at the (`SYS_HOLD`+2)-th rising edge of `pll_clk_i` after the condition first holds: two synchronizer edges plus `SYS_HOLD` (default 32). It changes only on that edge.
- R6: If the condition is interrupted before release, the next countdown restarts from zero and again takes the full `SYS_HOLD`+2 edges.
- R7: Right after power-up, before any clock edge, both `pll_rst_o` and `sys_rst_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_clk_i | input | 1 | Free-running external clock, drives the PLL reset delay |
| ext_rst_ni | input | 1 | External reset button, active low (0 = pressed) |
| pll_clk_i | input | 1 | PLL output clock, drives the system reset delay |
| pll_locked_i | input | 1 | PLL lock flag, 1 = locked |
| pll_rst_o | output | 1 | Reset to the PLL, active high |
| sys_rst_o | output | 1 | System reset for logic on the PLL clock, active high |

## Verification
The assertions assume that `pll_locked_i` and `ext_rst_ni` never change exactly on a `pll_clk_i` rising edge. They also assume that any drop in the release condition lasts until at least the next PLL clock edge. The stimulus meets both by changing these inputs only on falling edges of `pll_clk_i` and holding each value for at least one full period. It also raises lock only after `pll_rst_o` has been released, as a real PLL would.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned PLL_HOLD_DEF = 16;
  localparam int unsigned SYS_HOLD_DEF = 32;
  localparam int unsigned SYNC_LEN_DEF = 2;
  typedef enum logic {REL_BLOCKED = 1'b0, REL_ALLOWED = 1'b1} rel_cond_e;
endpackage

// File: rtl/rst_shift.sv
// Ones-filling shift register; optional asynchronous clear.
module rst_shift #(
  parameter int unsigned LEN     = 4,
  parameter bit          HAS_CLR = 1'b1
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned W = (LEN < 1) ? 1 : LEN;

  logic [W-1:0] sr = '0;

  generate
    if (HAS_CLR) begin : g_clr
      if (W == 1) begin : g_one
        always_ff @(posedge clk_i or negedge clr_ni)
          if (!clr_ni) sr <= '0;
          else         sr <= d_i;
      end else begin : g_many
        always_ff @(posedge clk_i or negedge clr_ni)
          if (!clr_ni) sr <= '0;
          else         sr <= {sr[W-2:0], d_i};
      end
    end else begin : g_noclr
      logic unused_clr;
      assign unused_clr = clr_ni;
      if (W == 1) begin : g_one
        always_ff @(posedge clk_i) sr <= d_i;
      end else begin : g_many
        always_ff @(posedge clk_i) sr <= {sr[W-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[W-1];
endmodule

// File: rtl/rel_cond.sv
// Release permission: PLL locked and button not pressed.
module rel_cond
  import rst_seq_pkg::*;
(
  input  logic      locked_i,
  input  logic      btn_ni,
  output rel_cond_e cond_o
);
  always_comb cond_o = (locked_i && btn_ni) ? REL_ALLOWED : REL_BLOCKED;
endmodule

// File: rtl/pll_rst_seq.sv
module pll_rst_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned PLL_HOLD = PLL_HOLD_DEF,
  parameter int unsigned SYS_HOLD = SYS_HOLD_DEF,
  parameter int unsigned SYNC_LEN = SYNC_LEN_DEF
) (
  input  logic ext_clk_i,
  input  logic ext_rst_ni,
  input  logic pll_clk_i,
  input  logic pll_locked_i,
  output logic pll_rst_o,
  output logic sys_rst_o
);
  logic      pll_free;
  rel_cond_e cond;
  logic      clr_n;
  logic      sync_q;
  logic      sys_free;

  // Stage 1: external-clock delay, no clear after power-up.
  rst_shift #(.LEN(PLL_HOLD), .HAS_CLR(1'b0)) u_pll_dly (
    .clk_i (ext_clk_i),
    .clr_ni(1'b1),
    .d_i   (1'b1),
    .q_o   (pll_free)
  );

  rel_cond u_cond (
    .locked_i(pll_locked_i),
    .btn_ni  (ext_rst_ni),
    .cond_o  (cond)
  );

  assign clr_n = (cond == REL_ALLOWED);

  // Stage 2a: reset synchronizer, asynchronous assert.
  rst_shift #(.LEN(SYNC_LEN), .HAS_CLR(1'b1)) u_sync (
    .clk_i (pll_clk_i),
    .clr_ni(clr_n),
    .d_i   (1'b1),
    .q_o   (sync_q)
  );

  // Stage 2b: PLL-clock delay, cleared with the synchronizer.
  rst_shift #(.LEN(SYS_HOLD), .HAS_CLR(1'b1)) u_sys_dly (
    .clk_i (pll_clk_i),
    .clr_ni(clr_n),
    .d_i   (sync_q),
    .q_o   (sys_free)
  );

  assign pll_rst_o = ~pll_free;
  assign sys_rst_o = ~sys_free;
endmodule

// File: rtl/pll_rst_seq_chk.sv
module pll_rst_seq_chk (
  input logic ext_clk_i,
  input logic ext_rst_ni,
  input logic pll_clk_i,
  input logic pll_locked_i,
  input logic pll_rst_o,
  input logic sys_rst_o
);
  logic ext_live = 1'b0;
  logic pll_live = 1'b0;
  logic go;

  always_ff @(posedge ext_clk_i) ext_live <= 1'b1;
  always_ff @(posedge pll_clk_i) pll_live <= 1'b1;
  assign go = pll_locked_i && ext_rst_ni;

  a_r2_pll_stays_released: assert property (@(posedge ext_clk_i) disable iff (!ext_live)
    !pll_rst_o |=> !pll_rst_o);

  a_r3_held_when_blocked: assert property (@(posedge pll_clk_i) disable iff (!pll_live)
    !go |-> sys_rst_o);

  a_r5_release_needs_cond: assert property (@(posedge pll_clk_i) disable iff (!pll_live)
    $fell(sys_rst_o) |-> ($past(go) && go));

  a_r4_rise_only_blocked: assert property (@(posedge pll_clk_i) disable iff (!pll_live)
    $rose(sys_rst_o) |-> !go);

  a_r5_pll_first: assert property (@(posedge pll_clk_i) disable iff (!pll_live)
    $fell(sys_rst_o) |-> !pll_rst_o);
endmodule

bind pll_rst_seq pll_rst_seq_chk u_chk (.*);

// File: tb/pll_rst_seq_tb_top.sv
module pll_rst_seq_tb_top;
  localparam int N = 16;
  localparam int M = 32;

  logic ext_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic btn_n   = 1'b1;
  logic locked  = 1'b0;
  logic pll_rst, sys_rst;

  int total = 0;
  int bad   = 0;
  int ext_edges = 0;
  int cnt = 0;
  bit restarted = 1'b0;
  bit done = 1'b0;

  always #5 ext_clk = ~ext_clk;
  always #3 pll_clk = ~pll_clk;

  pll_rst_seq dut_i (
    .ext_clk_i   (ext_clk),
    .ext_rst_ni  (btn_n),
    .pll_clk_i   (pll_clk),
    .pll_locked_i(locked),
    .pll_rst_o   (pll_rst),
    .sys_rst_o   (sys_rst)
  );

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // R7: power-up state
  initial begin
    #1;
    check(pll_rst, 1'b1, "R7 pll_rst");
    check(sys_rst, 1'b1, "R7 sys_rst");
  end

  // R1/R2 reference: edge count on ext_clk
  initial forever begin
    @(posedge ext_clk); #1;
    ext_edges++;
    check(pll_rst, logic'(ext_edges < N), (ext_edges <= N) ? "R1" : "R2");
  end

  // R3/R5/R6 reference: count of edges with release allowed
  initial forever begin
    @(posedge pll_clk); #1;
    if (locked && btn_n) begin
      if (cnt < M + 2) cnt++;
    end else cnt = 0;
    check(sys_rst, logic'(cnt < M + 2),
          !(locked && btn_n) ? "R3" : (restarted ? "R6" : "R5"));
  end

  task automatic set_in(input logic l, input logic b);
    @(negedge pll_clk);
    locked = l;
    btn_n  = b;
    #1;
    if (!(l && b)) check(sys_rst, 1'b1, "R4 async assert");
  endtask

  initial begin
    set_in(1'b0, 1'b1);
    repeat (N + 4) @(posedge ext_clk);
    set_in(1'b1, 1'b1);                 // R5 normal release
    repeat (M + 8) @(posedge pll_clk);
    set_in(1'b1, 1'b0);                 // R4 button press after release
    repeat (4) @(posedge pll_clk);
    set_in(1'b1, 1'b1);
    repeat (15) @(posedge pll_clk);
    set_in(1'b0, 1'b1);                 // lock lost mid-count
    repeat (2) @(posedge pll_clk);
    restarted = 1'b1;                   // R6 full restart
    set_in(1'b1, 1'b1);
    repeat (M + 8) @(posedge pll_clk);
    restarted = 1'b0;
    set_in(1'b0, 1'b1);                 // R4 lock loss after release
    set_in(1'b0, 1'b0);
    repeat (3) @(posedge pll_clk);
    set_in(1'b1, 1'b0);                 // R3 locked but button held
    repeat (M + 6) @(posedge pll_clk);
    set_in(1'b1, 1'b1);
    repeat (M + 8) @(posedge pll_clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog t=%0t actual=running expected=done", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule